// File: doc/BRIEF.md
# Double-Precision Predicate Comparator

This block compares two IEEE-754 binary64 values, A and B, under a 5-bit predicate code and returns one true/false result. Each operand is first sorted into a class: zero, subnormal, normal, infinity, quiet NaN or signaling NaN. The classes and the sign-magnitude fields then settle which single relation holds: A greater, A less, equal, or unordered. The predicate code maps that relation to the result and also says whether the predicate is a signaling one.

Two flags go with the result. The invalid flag reports a signaling NaN input, or a quiet NaN input compared under a signaling predicate. The denormal flag reports a subnormal input. A mode input picks the legacy encoding, where only the low three predicate bits count, or the extended encoding, where five bits count. The unit is purely combinational. Masking of the flags, status accumulation and traps belong to the surrounding pipeline.

Top module: `dp_pred_cmp`

## Requirements
- R1: Exactly one relation holds for each pair: greater, less, equal or unordered. The pair is unordered if and only if at least one operand is a NaN (exponent all ones, fraction nonzero).
- R2: Effective codes 0..7 give, in order: equal, less, less-or-equal, unordered, not-equal, not-less, not-less-or-equal, ordered. Codes 4..7 are the exact complements of codes 0..3, including for unordered pairs.
- R3: Effective codes 8..15 give, in order: equal-or-unordered, less-or-unordered, less-equal-or-unordered, always false, greater-or-less, greater-or-equal, greater, always true.
- R4: Effective codes 16..31 give the same result as the code 16 lower.
- R5: invalid_o is 1 whenever either operand is a signaling NaN (exponent all ones, fraction bit 51 clear, fraction nonzero), whatever the predicate.
- R6: With quiet NaNs only (fraction bit 51 set), invalid_o is 1 exactly when the predicate is signaling. Signaling codes are 1, 2, 5, 6, 9, 10, 13 and 14, plus codes 16..31 whose low-four-bit code is not in that list. invalid_o is 0 for ordered, NaN-free pairs.
- R7: With ext_mode_i = 0 the effective code is pred_i[2:0]. With ext_mode_i = 1 it is pred_i[4:0]. pred_i bits 7:5 never affect any output, and neither do bits 4:3 in legacy mode.
- R8: denormal_o is 1 exactly when either operand has a zero exponent and a nonzero fraction.
- R9: +0 and -0 compare equal. Two infinities of the same sign compare equal.
- R10: Ordered, nonzero operands are ordered by value: a positive value is above a negative one, and among negative values the one with the larger magnitude is the smaller.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | Operand A, binary64 |
| b_i | input | 64 | Operand B, binary64 |
| pred_i | input | 8 | Predicate byte; bits used depend on ext_mode_i |
| ext_mode_i | input | 1 | 1: five-bit predicate, 0: three-bit legacy predicate |
| result_o | output | 1 | Predicate outcome |
| invalid_o | output | 1 | Invalid-operation flag |
| denormal_o | output | 1 | Subnormal operand flag |

## Verification
Uniform random 64-bit words almost never produce equal operands, signed zeros, matching infinities or NaNs with a chosen quiet bit. Those cases drive the equality, unordered and invalid paths, so the stimulus builds each operand from a chosen class. It often copies or sign-flips A into B and keeps normal exponents in a narrow band, so that ties in exponent and equal values come up often. Directed cases cover signed zeros, negative ordering, the quiet-NaN invalid rule under the inverted-signaling codes, and the legacy-mode truncation with upper bits set.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int PRED_W = 8;
  localparam int CODE_W = 5;
  localparam int LEG_W  = 3;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_SUB,
    CLS_NORM,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN
  } fp_cls_e;

  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
    logic un;
  } rel_t;
endpackage

// File: rtl/fp_classify.sv
module fp_classify
  import dpc_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W,
  localparam int W = 1 + EW + FW
) (
  input  logic [W-1:0]     op_i,
  output fp_cls_e          cls_o,
  output logic             sign_o,
  output logic [EW+FW-1:0] mag_o
);
  logic [EW-1:0] exp_w;
  logic [FW-1:0] frac_w;
  logic          exp_zero, exp_ones, frac_zero;

  assign exp_w     = op_i[W-2 -: EW];
  assign frac_w    = op_i[FW-1:0];
  assign exp_zero  = (exp_w == '0);
  assign exp_ones  = (exp_w == '1);
  assign frac_zero = (frac_w == '0);
  assign sign_o    = op_i[W-1];
  assign mag_o     = op_i[W-2:0];

  always_comb begin
    if (exp_zero)       cls_o = frac_zero ? CLS_ZERO : CLS_SUB;
    else if (!exp_ones) cls_o = CLS_NORM;
    else if (frac_zero) cls_o = CLS_INF;
    else                cls_o = frac_w[FW-1] ? CLS_QNAN : CLS_SNAN;
  end
endmodule

// File: rtl/fp_relation.sv
module fp_relation
  import dpc_pkg::*;
#(
  parameter int MW = EXP_W + FRAC_W
) (
  input  fp_cls_e       cls_a_i,
  input  fp_cls_e       cls_b_i,
  input  logic          sign_a_i,
  input  logic          sign_b_i,
  input  logic [MW-1:0] mag_a_i,
  input  logic [MW-1:0] mag_b_i,
  output rel_t          rel_o
);
  logic nan_a, nan_b, both_zero, mag_eq, mag_gt, a_above;

  assign nan_a     = (cls_a_i == CLS_QNAN) || (cls_a_i == CLS_SNAN);
  assign nan_b     = (cls_b_i == CLS_QNAN) || (cls_b_i == CLS_SNAN);
  assign both_zero = (cls_a_i == CLS_ZERO) && (cls_b_i == CLS_ZERO);
  assign mag_eq    = (mag_a_i == mag_b_i);
  assign mag_gt    = (mag_a_i > mag_b_i);
  // opposite signs: the positive one is above; same sign: magnitude, reversed when negative
  assign a_above   = (sign_a_i != sign_b_i) ? sign_b_i : (mag_gt ^ sign_a_i);

  always_comb begin
    rel_o = '0;
    if (nan_a || nan_b)                           rel_o.un = 1'b1;
    else if (both_zero)                           rel_o.eq = 1'b1;
    else if (sign_a_i == sign_b_i && mag_eq)      rel_o.eq = 1'b1;
    else if (a_above)                             rel_o.gt = 1'b1;
    else                                          rel_o.lt = 1'b1;
  end

  always_comb begin
    if (!$isunknown({cls_a_i, cls_b_i})) begin
      AST_ONE_REL: assert ($onehot({rel_o.gt, rel_o.lt, rel_o.eq, rel_o.un})); // R1
      AST_ORDERED_NO_UN: assert (nan_a || nan_b || !rel_o.un); // R1
    end
  end
endmodule

// File: rtl/pred_eval.sv
module pred_eval
  import dpc_pkg::*;
#(
  parameter int PW = PRED_W,
  parameter int CW = CODE_W,
  parameter int LW = LEG_W
) (
  input  logic [PW-1:0] pred_i,
  input  logic          ext_i,
  input  rel_t          rel_i,
  output logic          hit_o,
  output logic          sig_o
);
  logic [CW-1:0] code;
  logic          base, unord_flip;

  // legacy encoding keeps only the low LW bits
  assign code = ext_i ? pred_i[CW-1:0] : {{(CW-LW){1'b0}}, pred_i[LW-1:0]};

  // bits [1:0] pick the relation set, bit 3 folds unordered in, bit 2 inverts, bit 4 flips signaling
  always_comb begin
    unique case (code[1:0])
      2'd0: base = rel_i.eq;
      2'd1: base = rel_i.lt;
      2'd2: base = rel_i.lt | rel_i.eq;
      default: base = rel_i.un;
    endcase
  end

  assign unord_flip = code[3] & rel_i.un;
  assign hit_o      = base ^ unord_flip ^ code[2];
  assign sig_o      = (code[1] ^ code[0]) ^ code[4];

  always_comb begin
    if (!$isunknown({pred_i, ext_i, rel_i})) begin
      AST_CONST_FALSE: assert (!(code[3:0] == 4'hB) || !hit_o); // R3
      AST_CONST_TRUE: assert (!(code[3:0] == 4'hF) || hit_o); // R3
      AST_ORD_COMPL: assert (!(code[3:0] == 4'h7) || (hit_o == !rel_i.un)); // R2
    end
  end
endmodule

// File: rtl/dp_pred_cmp.sv
module dp_pred_cmp
  import dpc_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W,
  parameter int PW = PRED_W,
  localparam int W  = 1 + EW + FW,
  localparam int MW = EW + FW
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [PW-1:0] pred_i,
  input  logic          ext_mode_i,
  output logic          result_o,
  output logic          invalid_o,
  output logic          denormal_o
);
  fp_cls_e       cls   [2];
  logic          sign  [2];
  logic [MW-1:0] mag   [2];
  logic [W-1:0]  ops   [2];
  rel_t          rel;
  logic          sig_pred, any_snan, any_qnan;

  assign ops[0] = a_i;
  assign ops[1] = b_i;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fp_classify #(.EW(EW), .FW(FW)) u_cls (
      .op_i  (ops[g]),
      .cls_o (cls[g]),
      .sign_o(sign[g]),
      .mag_o (mag[g])
    );
  end

  fp_relation #(.MW(MW)) u_rel (
    .cls_a_i (cls[0]),
    .cls_b_i (cls[1]),
    .sign_a_i(sign[0]),
    .sign_b_i(sign[1]),
    .mag_a_i (mag[0]),
    .mag_b_i (mag[1]),
    .rel_o   (rel)
  );

  pred_eval #(.PW(PW)) u_pred (
    .pred_i(pred_i),
    .ext_i (ext_mode_i),
    .rel_i (rel),
    .hit_o (result_o),
    .sig_o (sig_pred)
  );

  assign any_snan   = (cls[0] == CLS_SNAN) || (cls[1] == CLS_SNAN);
  assign any_qnan   = (cls[0] == CLS_QNAN) || (cls[1] == CLS_QNAN);
  assign invalid_o  = any_snan || (any_qnan && sig_pred);
  assign denormal_o = (cls[0] == CLS_SUB) || (cls[1] == CLS_SUB);

  always_comb begin
    if (!$isunknown({a_i, b_i, pred_i, ext_mode_i})) begin
      AST_SNAN_INVALID: assert (!((a_i[W-2 -: EW] == '1) && !a_i[FW-1] && (a_i[FW-2:0] != '0)) || invalid_o); // R5
      AST_ORDERED_QUIET: assert (!(rel.gt || rel.lt || rel.eq) || !invalid_o); // R6
      AST_SIGNED_ZERO: assert (!((a_i[W-2:0] == '0) && (b_i[W-2:0] == '0)) || rel.eq); // R9
      AST_DENORM_FLAG: assert (denormal_o == (((a_i[W-2 -: EW] == '0) && (a_i[FW-1:0] != '0)) ||
                                             ((b_i[W-2 -: EW] == '0) && (b_i[FW-1:0] != '0)))); // R8
    end
  end
endmodule

// File: tb/tb_dp_pred_cmp.sv
module tb_dp_pred_cmp;
  logic        clk = 1'b0;
  logic [63:0] a, b;
  logic [7:0]  pred;
  logic        ext;
  logic        res, inv, den;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dp_pred_cmp dut (
    .a_i(a), .b_i(b), .pred_i(pred), .ext_mode_i(ext),
    .result_o(res), .invalid_o(inv), .denormal_o(den)
  );

  function automatic bit is_nan(input logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction

  function automatic bit is_snan(input logic [63:0] x);
    return is_nan(x) && !x[51];
  endfunction

  function automatic bit is_sub(input logic [63:0] x);
    return (x[62:52] == 0) && (x[51:0] != 0);
  endfunction

  function automatic bit exp_result(input logic [63:0] x, input logic [63:0] y, input logic [4:0] c);
    bit g, l, e, u;
    real rx, ry;
    rx = $bitstoreal(x);
    ry = $bitstoreal(y);
    u = is_nan(x) || is_nan(y);
    g = !u && (rx > ry);
    l = !u && (rx < ry);
    e = !u && !g && !l;
    case (c[3:0])
      4'h0: return e;
      4'h1: return l;
      4'h2: return l | e;
      4'h3: return u;
      4'h4: return !e;
      4'h5: return !l;
      4'h6: return !(l | e);
      4'h7: return !u;
      4'h8: return e | u;
      4'h9: return l | u;
      4'hA: return l | e | u;
      4'hB: return 1'b0;
      4'hC: return g | l;
      4'hD: return g | e;
      4'hE: return g;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit exp_sig(input logic [4:0] c);
    bit s;
    s = (c[3:0] inside {4'h1, 4'h2, 4'h5, 4'h6, 4'h9, 4'hA, 4'hD, 4'hE});
    return s ^ c[4];
  endfunction

  function automatic logic [63:0] gen(input int kind);
    logic s;
    logic [51:0] f;
    s = 1'($urandom);
    f = {$urandom, $urandom};
    case (kind)
      0: return {s, 63'd0};
      1: return {s, 11'd0, (f == 0) ? 52'd1 : f};
      2: return {s, 11'(1020 + $urandom % 6), f[51:0] & {48'd0, 4'hF}};
      3: return {s, 11'h7FF, 52'd0};
      4: return {s, 11'h7FF, 1'b1, f[50:0]};
      default: return {s, 11'h7FF, 1'b0, (f[50:0] == 0) ? 51'd5 : f[50:0]};
    endcase
  endfunction

  task automatic check(input bit act, input bit expv, input string req, input string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: a=%h b=%h pred=%h ext=%0b actual=%0b expected=%0b",
               req, what, a, b, pred, ext, act, expv);
    end
  endtask

  task automatic apply(input logic [63:0] x, input logic [63:0] y, input logic [7:0] p, input bit e);
    logic [4:0] c;
    string rq;
    @(posedge clk);
    a = x; b = y; pred = p; ext = e;
    @(negedge clk);
    c = e ? p[4:0] : {2'b0, p[2:0]};
    rq = (c < 8) ? "R2" : (c < 16) ? "R3" : "R4";
    check(res, exp_result(x, y, c), rq, "result");
    check(inv, is_snan(x) || is_snan(y) || ((is_nan(x) || is_nan(y)) && exp_sig(c)), "R5_R6", "invalid");
    check(den, is_sub(x) || is_sub(y), "R8", "denormal");
  endtask

  localparam logic [63:0] P_ZERO = 64'h0;
  localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] P_ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] N_ONE  = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] N_TWO  = 64'hC000_0000_0000_0000;
  localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] QNAN   = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN   = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] SUBN   = 64'h0000_0000_0000_0003;

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C3A));
    a = '0; b = '0; pred = '0; ext = 1'b0;
    @(negedge clk);
    // idle inputs: zero vs zero under equal gives true, no flags
    check(res, 1'b1, "R9", "idle result");
    check(inv, 1'b0, "R6", "idle invalid");
    check(den, 1'b0, "R8", "idle denormal");

    apply(P_ZERO, N_ZERO, 8'h00, 1'b1);                 // R9 signed zeros equal
    check(res, 1'b1, "R9", "+0 == -0");
    apply(P_INF, P_INF, 8'h0D, 1'b1);                   // R9 infinities equal
    check(res, 1'b1, "R9", "inf >= inf");
    apply(N_ONE, N_TWO, 8'h0E, 1'b1);                   // R10 -1 > -2
    check(res, 1'b1, "R10", "-1 > -2");
    apply(N_ONE, P_ONE, 8'h01, 1'b1);                   // R10 negative below positive
    check(res, 1'b1, "R10", "-1 < +1");
    apply(QNAN, P_ONE, 8'h00, 1'b1);                    // R6 quiet code
    check(inv, 1'b0, "R6", "qnan quiet eq");
    apply(QNAN, P_ONE, 8'h11, 1'b1);                    // R6 code 0x11 quiet
    check(inv, 1'b0, "R6", "qnan code 11h");
    apply(P_ONE, QNAN, 8'h10, 1'b1);                    // R6 code 0x10 signaling
    check(inv, 1'b1, "R6", "qnan code 10h");
    apply(SNAN, P_ONE, 8'h03, 1'b1);                    // R5 snan always invalid
    check(inv, 1'b1, "R5", "snan unord");
    check(res, 1'b1, "R1", "snan unordered");
    apply(QNAN, QNAN, 8'h04, 1'b0);                     // R2 complement under unordered
    check(res, 1'b1, "R2", "neq on nan");
    apply(P_ONE, N_ONE, 8'hFD, 1'b0);                   // R7 legacy: code 5 (not-less)
    check(res, 1'b1, "R7", "legacy truncation");
    apply(N_ONE, P_ONE, 8'hFD, 1'b0);
    check(res, 1'b0, "R7", "legacy truncation low");
    apply(N_ONE, P_ONE, 8'hE1, 1'b1);                   // R7 ext ignores bits 7:5
    check(res, 1'b1, "R7", "ext upper bits");
    apply(SUBN, P_ONE, 8'h0B, 1'b1);                    // R8, R3 always false
    check(den, 1'b1, "R8", "subnormal");
    check(res, 1'b0, "R3", "false");
    apply(QNAN, P_INF, 8'h1F, 1'b1);                    // R4 true, signaling
    check(res, 1'b1, "R4", "true 1Fh");
    check(inv, 1'b1, "R6", "true 1Fh signaling");

    for (int i = 0; i < 4000; i++) begin
      logic [63:0] x, y;
      int m;
      x = gen($urandom % 6);
      m = $urandom % 8;
      if (m == 0)      y = x;
      else if (m == 1) y = {~x[63], x[62:0]};
      else             y = gen($urandom % 6);
      if ($urandom % 2) apply(x, y, 8'($urandom), 1'($urandom));
      else              apply(y, x, 8'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule